// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block sits between decode and a set of integer functional units. Decoded instructions arrive one per cycle with a destination register and two source registers. They wait in a small ordered queue and leave it out of program order. Each cycle the queue sends at most one instruction to a free unit. It picks the longest-waiting entry whose operands are not still being produced.

Read-after-write dependences come from a table of in-flight destinations, not from a scoreboard. Every accepted instruction takes a slot in that table, which records its destination register. The slot number travels with the instruction as a tag and comes back from writeback on the retire port. The slot is released only then. When an instruction is accepted, it notes which live slots hold a register it reads. It stays blocked until every one of those slots has retired.

Queue depth, table size, unit count and payload width are all parameters.

Top module: `ooo_issue_queue`

## Requirements
- R1: While reset is held and right after it is released, the queue is empty: `in_ready_o` is 1 and `iss_valid_o` is 0.
- R2: An instruction is taken at a rising edge where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` is 0 whenever DEPTH instructions are queued or all NSLOT tags are live. In either case the input is ignored, and later issue order and tags show that nothing was stored.
- R3: An accepted instruction gets the lowest-numbered tag that is not live. The tag comes out on `iss_tag_o` when the instruction issues. It stays live until `ret_valid_i` presents it at a rising edge.
- R4: A source register that is nonzero and equals the destination of a tag that is live at acceptance blocks the instruction. The instruction cannot issue until every such tag has retired.
- R5: Register 0 creates no dependence. A destination of 0 blocks nobody, and a source of 0 never waits.
- R6: Of the unblocked queued instructions, the one accepted earliest issues. The others keep their relative order after an entry is removed from anywhere in the queue.
- R7: At most one instruction issues per cycle, and only when `fu_free_i` is nonzero. `iss_fu_o` is one-hot and selects the lowest-numbered bit set in `fu_free_i`. It is all zeros when nothing issues.
- R8: Issue outputs come straight from stored state. An instruction accepted at an edge can issue in the next cycle. A retire at an edge unblocks its dependents in the next cycle. An instruction accepted at the same edge where a matching tag retires does not wait for that tag.
- R9: An instruction leaves the queue at every rising edge where `iss_valid_o` is 1. There is no separate acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_ready_o | output | 1 | Queue can take an instruction |
| in_op_i | input | OP_W | Opaque operation payload |
| in_rd_i | input | 5 | Destination register |
| in_rs1_i | input | 5 | First source register |
| in_rs2_i | input | 5 | Second source register |
| fu_free_i | input | NUM_FU | One bit per functional unit that can take work |
| iss_valid_o | output | 1 | An instruction issues this cycle |
| iss_fu_o | output | NUM_FU | One-hot target unit |
| iss_op_o | output | OP_W | Payload of the issued instruction |
| iss_rd_o | output | 5 | Destination of the issued instruction |
| iss_rs1_o | output | 5 | First source of the issued instruction |
| iss_rs2_o | output | 5 | Second source of the issued instruction |
| iss_tag_o | output | TAG_W | In-flight tag of the issued instruction |
| ret_valid_i | input | 1 | Writeback retires a tag |
| ret_tag_i | input | TAG_W | Tag being retired |

## Verification
The assertions assume that writeback retires only a tag that is live, and that it retires each issued tag once. They also assume the tag presented is below NSLOT. The bench keeps a list of tags the queue has issued and not yet retired. It chooses every retire from that list and removes the tag when it is used, so the retire port never carries a stale or repeated tag. Source and destination registers are drawn from a small range so that dependences are frequent.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned REG_AW = 5;
  typedef logic [REG_AW-1:0] reg_idx_t;
  typedef struct packed {
    reg_idx_t rd;
    reg_idx_t rs1;
    reg_idx_t rs2;
  } reg_fields_t;
endpackage

// File: rtl/iq_dest_table.sv
module iq_dest_table
  import iq_pkg::*;
#(
  parameter int unsigned NSLOT = 6,
  parameter int unsigned TAG_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  reg_idx_t         alloc_rd_i,
  input  logic             free_i,
  input  logic [TAG_W-1:0] free_tag_i,
  input  reg_idx_t         rs1_i,
  input  reg_idx_t         rs2_i,
  output logic             any_free_o,
  output logic [TAG_W-1:0] alloc_tag_o,
  output logic [NSLOT-1:0] dep_o
);
  logic             live_q [NSLOT];
  reg_idx_t         rd_q   [NSLOT];
  logic [NSLOT-1:0] live_vec;
  logic [NSLOT-1:0] kill;

  always_comb begin
    any_free_o  = 1'b0;
    alloc_tag_o = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        any_free_o  = 1'b1;
        alloc_tag_o = TAG_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic set;
    assign set         = alloc_i && (alloc_tag_o == TAG_W'(g));
    assign kill[g]     = free_i && (free_tag_i == TAG_W'(g));
    assign live_vec[g] = live_q[g];
    // a slot retiring this edge no longer counts as a producer
    assign dep_o[g] = live_q[g] && !kill[g] && (rd_q[g] != '0) &&
                      (((rs1_i != '0) && (rs1_i == rd_q[g])) ||
                       ((rs2_i != '0) && (rs2_i == rd_q[g])));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[g] <= 1'b0;
        rd_q[g]   <= '0;
      end else if (set) begin
        live_q[g] <= 1'b1;
        rd_q[g]   <= alloc_rd_i;
      end else if (kill[g]) begin
        live_q[g] <= 1'b0;
      end
    end
  end

  p_retire_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> (int'(free_tag_i) < NSLOT) && live_vec[free_tag_i]);
  p_alloc_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !live_vec[alloc_tag_o]);
  p_alloc_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> live_vec[$past(alloc_tag_o)]);
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned NUM_FU = 2,
  parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEPTH-1:0]  rdy_i,
  input  logic [NUM_FU-1:0] fu_free_i,
  output logic              issue_o,
  output logic [IDX_W-1:0]  pick_idx_o,
  output logic [NUM_FU-1:0] fu_oh_o
);
  logic [NUM_FU-1:0] fu_low;

  always_comb begin
    pick_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rdy_i[i]) pick_idx_o = IDX_W'(i);
    end
  end

  assign fu_low  = fu_free_i & (~fu_free_i + 1'b1);
  assign issue_o = (|rdy_i) && (|fu_free_i);
  assign fu_oh_o = issue_o ? fu_low : '0;

  p_one_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fu_oh_o));
  p_unit_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ((fu_oh_o & fu_free_i) != '0));
  p_pick_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> rdy_i[pick_idx_o]);
  p_oldest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ((rdy_i & ((DEPTH'(1) << pick_idx_o) - 1'b1)) == '0));
endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OP_W  = 8,
  parameter int unsigned NSLOT = 6,
  parameter int unsigned TAG_W = $clog2(NSLOT),
  parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic [OP_W-1:0]  enq_op_i,
  input  reg_fields_t      enq_regs_i,
  input  logic [TAG_W-1:0] enq_tag_i,
  input  logic [NSLOT-1:0] enq_dep_i,
  input  logic             deq_i,
  input  logic [IDX_W-1:0] deq_idx_i,
  input  logic             free_i,
  input  logic [TAG_W-1:0] free_tag_i,
  output logic             full_o,
  output logic [DEPTH-1:0] rdy_o,
  output logic [OP_W-1:0]  out_op_o,
  output reg_fields_t      out_regs_o,
  output logic [TAG_W-1:0] out_tag_o
);
  logic             vld_q  [DEPTH];
  logic [OP_W-1:0]  op_q   [DEPTH];
  reg_fields_t      regs_q [DEPTH];
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [NSLOT-1:0] dep_q  [DEPTH];

  logic             n_vld  [DEPTH];
  logic [OP_W-1:0]  n_op   [DEPTH];
  reg_fields_t      n_regs [DEPTH];
  logic [TAG_W-1:0] n_tag  [DEPTH];
  logic [NSLOT-1:0] n_dep  [DEPTH];
  logic [DEPTH-1:0] enq_sel;
  logic [DEPTH-1:0] vld_vec;
  logic [NSLOT-1:0] free_oh;

  for (genvar s = 0; s < NSLOT; s++) begin : g_free
    assign free_oh[s] = free_i && (free_tag_i == TAG_W'(s));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic shift;
    // entries above the removed one move down by one, keeping age order
    assign shift = deq_i && (IDX_W'(g) >= deq_idx_i);

    if (g < DEPTH - 1) begin : g_mid
      assign n_vld[g]  = shift ? vld_q[g+1]  : vld_q[g];
      assign n_op[g]   = shift ? op_q[g+1]   : op_q[g];
      assign n_regs[g] = shift ? regs_q[g+1] : regs_q[g];
      assign n_tag[g]  = shift ? tag_q[g+1]  : tag_q[g];
      assign n_dep[g]  = shift ? dep_q[g+1]  : dep_q[g];
    end else begin : g_top
      assign n_vld[g]  = shift ? 1'b0 : vld_q[g];
      assign n_op[g]   = op_q[g];
      assign n_regs[g] = regs_q[g];
      assign n_tag[g]  = tag_q[g];
      assign n_dep[g]  = dep_q[g];
    end

    if (g == 0) begin : g_first
      assign enq_sel[g] = enq_i && !n_vld[g];
    end else begin : g_rest
      assign enq_sel[g] = enq_i && !n_vld[g] && n_vld[g-1];
    end

    assign vld_vec[g] = vld_q[g];
    assign rdy_o[g]   = vld_q[g] && (dep_q[g] == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        op_q[g]   <= '0;
        regs_q[g] <= '0;
        tag_q[g]  <= '0;
        dep_q[g]  <= '0;
      end else begin
        vld_q[g] <= n_vld[g] | enq_sel[g];
        if (enq_sel[g]) begin
          op_q[g]   <= enq_op_i;
          regs_q[g] <= enq_regs_i;
          tag_q[g]  <= enq_tag_i;
          dep_q[g]  <= enq_dep_i;
        end else begin
          op_q[g]   <= n_op[g];
          regs_q[g] <= n_regs[g];
          tag_q[g]  <= n_tag[g];
          dep_q[g]  <= n_dep[g] & ~free_oh;
        end
      end
    end
  end

  assign full_o     = vld_q[DEPTH-1];
  assign out_op_o   = op_q[deq_idx_i];
  assign out_regs_o = regs_q[deq_idx_i];
  assign out_tag_o  = tag_q[deq_idx_i];

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |-> !vld_vec[DEPTH-1]);
  p_deq_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> vld_vec[deq_idx_i]);
  p_packed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_vec & (vld_vec + 1'b1)) == '0);
  p_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(vld_vec) ==
             $countones($past(vld_vec)) + int'($past(enq_i)) - int'($past(deq_i)));
endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned NUM_FU = 2,
  parameter int unsigned NSLOT  = 6,
  parameter int unsigned OP_W   = 8,
  localparam int unsigned TAG_W = $clog2(NSLOT),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OP_W-1:0]   in_op_i,
  input  logic [REG_AW-1:0] in_rd_i,
  input  logic [REG_AW-1:0] in_rs1_i,
  input  logic [REG_AW-1:0] in_rs2_i,
  input  logic [NUM_FU-1:0] fu_free_i,
  output logic              iss_valid_o,
  output logic [NUM_FU-1:0] iss_fu_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [REG_AW-1:0] iss_rd_o,
  output logic [REG_AW-1:0] iss_rs1_o,
  output logic [REG_AW-1:0] iss_rs2_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i
);
  logic             accept;
  logic             any_free;
  logic             full;
  logic [TAG_W-1:0] new_tag;
  logic [NSLOT-1:0] new_dep;
  logic [DEPTH-1:0] rdy;
  logic [IDX_W-1:0] pick_idx;
  logic             issue;
  reg_fields_t      in_regs;
  reg_fields_t      out_regs;

  assign in_regs    = '{rd: in_rd_i, rs1: in_rs1_i, rs2: in_rs2_i};
  assign in_ready_o = !full && any_free;
  assign accept     = in_valid_i && in_ready_o;

  iq_dest_table #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (accept),
    .alloc_rd_i (in_rd_i),
    .free_i     (ret_valid_i),
    .free_tag_i (ret_tag_i),
    .rs1_i      (in_rs1_i),
    .rs2_i      (in_rs2_i),
    .any_free_o (any_free),
    .alloc_tag_o(new_tag),
    .dep_o      (new_dep)
  );

  iq_store #(
    .DEPTH(DEPTH), .OP_W(OP_W), .NSLOT(NSLOT), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enq_i     (accept),
    .enq_op_i  (in_op_i),
    .enq_regs_i(in_regs),
    .enq_tag_i (new_tag),
    .enq_dep_i (new_dep),
    .deq_i     (issue),
    .deq_idx_i (pick_idx),
    .free_i    (ret_valid_i),
    .free_tag_i(ret_tag_i),
    .full_o    (full),
    .rdy_o     (rdy),
    .out_op_o  (iss_op_o),
    .out_regs_o(out_regs),
    .out_tag_o (iss_tag_o)
  );

  iq_select #(.DEPTH(DEPTH), .NUM_FU(NUM_FU), .IDX_W(IDX_W)) u_select (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdy_i     (rdy),
    .fu_free_i (fu_free_i),
    .issue_o   (issue),
    .pick_idx_o(pick_idx),
    .fu_oh_o   (iss_fu_o)
  );

  assign iss_valid_o = issue;
  assign iss_rd_o    = out_regs.rd;
  assign iss_rs1_o   = out_regs.rs1;
  assign iss_rs2_o   = out_regs.rs2;

  p_idle_units_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fu_free_i == '0) |-> !iss_valid_o);
  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !in_ready_o);
endmodule

// File: tb/ooo_issue_queue_tb.sv
module ooo_issue_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int NUM_FU = 2;
  localparam int NSLOT  = 6;
  localparam int OP_W   = 8;
  localparam int TAG_W  = $clog2(NSLOT);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic [OP_W-1:0]   in_op_i = '0;
  logic [4:0]        in_rd_i = '0, in_rs1_i = '0, in_rs2_i = '0;
  logic [NUM_FU-1:0] fu_free_i = '0;
  logic              iss_valid_o;
  logic [NUM_FU-1:0] iss_fu_o;
  logic [OP_W-1:0]   iss_op_o;
  logic [4:0]        iss_rd_o, iss_rs1_o, iss_rs2_o;
  logic [TAG_W-1:0]  iss_tag_o;
  logic              ret_valid_i = 1'b0;
  logic [TAG_W-1:0]  ret_tag_i = '0;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int m_n = 0;
  int m_op [DEPTH];
  int m_rd [DEPTH];
  int m_tag[DEPTH];
  int m_dep[DEPTH];
  bit s_live[NSLOT];
  int s_rd [NSLOT];
  int outstanding[$];

  ooo_issue_queue #(.DEPTH(DEPTH), .NUM_FU(NUM_FU), .NSLOT(NSLOT), .OP_W(OP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_op_i(in_op_i), .in_rd_i(in_rd_i), .in_rs1_i(in_rs1_i), .in_rs2_i(in_rs2_i),
    .fu_free_i(fu_free_i), .iss_valid_o(iss_valid_o), .iss_fu_o(iss_fu_o),
    .iss_op_o(iss_op_o), .iss_rd_o(iss_rd_o), .iss_rs1_o(iss_rs1_o), .iss_rs2_o(iss_rs2_o),
    .iss_tag_o(iss_tag_o), .ret_valid_i(ret_valid_i), .ret_tag_i(ret_tag_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pick();
    for (int i = 0; i < m_n; i++) if (m_dep[i] == 0) return i;
    return -1;
  endfunction

  function automatic int low_fu();
    for (int i = 0; i < NUM_FU; i++) if (fu_free_i[i]) return i;
    return -1;
  endfunction

  function automatic int low_slot();
    for (int i = 0; i < NSLOT; i++) if (!s_live[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_ready();
    return (m_n < DEPTH) && (low_slot() >= 0);
  endfunction

  function automatic bit exp_issue();
    return (exp_pick() >= 0) && (low_fu() >= 0);
  endfunction

  // compare one cycle against the model, clock it, advance the model
  task automatic step();
    int pk, fu, ns, nd;
    bit rdy, iss, acc;
    #1;
    pk = exp_pick(); fu = low_fu(); rdy = exp_ready(); iss = exp_issue();
    chk(in_ready_o == rdy, "R2 R3", int'(in_ready_o), int'(rdy));
    chk(iss_valid_o == iss, "R4 R5 R7 R8", int'(iss_valid_o), int'(iss));
    if (iss) begin
      chk(int'(iss_op_o) == m_op[pk], "R6 R9", int'(iss_op_o), m_op[pk]);
      chk(int'(iss_rd_o) == m_rd[pk], "R6", int'(iss_rd_o), m_rd[pk]);
      chk(int'(iss_tag_o) == m_tag[pk], "R3", int'(iss_tag_o), m_tag[pk]);
      chk(int'(iss_fu_o) == (1 << fu), "R7", int'(iss_fu_o), 1 << fu);
    end else begin
      chk(iss_fu_o == '0, "R7", int'(iss_fu_o), 0);
    end
    acc = in_valid_i && rdy;
    ns  = low_slot();
    nd  = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (s_live[s] && !(ret_valid_i && int'(ret_tag_i) == s) && s_rd[s] != 0 &&
          ((in_rs1_i != 0 && int'(in_rs1_i) == s_rd[s]) ||
           (in_rs2_i != 0 && int'(in_rs2_i) == s_rd[s])))
        nd |= (1 << s);
    end
    @(posedge clk);
    if (ret_valid_i) begin
      s_live[ret_tag_i] = 1'b0;
      for (int i = 0; i < DEPTH; i++) m_dep[i] &= ~(1 << int'(ret_tag_i));
      for (int i = 0; i < outstanding.size(); i++)
        if (outstanding[i] == int'(ret_tag_i)) begin outstanding.delete(i); break; end
    end
    if (iss) begin
      outstanding.push_back(m_tag[pk]);
      for (int i = pk; i < m_n - 1; i++) begin
        m_op[i] = m_op[i+1]; m_rd[i] = m_rd[i+1];
        m_tag[i] = m_tag[i+1]; m_dep[i] = m_dep[i+1];
      end
      m_n--;
    end
    if (acc) begin
      s_live[ns] = 1'b1; s_rd[ns] = int'(in_rd_i);
      m_op[m_n] = int'(in_op_i); m_rd[m_n] = int'(in_rd_i);
      m_tag[m_n] = ns; m_dep[m_n] = nd;
      m_n++;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit v, int op, int rd, int rs1, int rs2, int ff, bit rv, int rt);
    in_valid_i = v; in_op_i = OP_W'(op);
    in_rd_i = 5'(rd); in_rs1_i = 5'(rs1); in_rs2_i = 5'(rs2);
    fu_free_i = NUM_FU'(ff); ret_valid_i = rv; ret_tag_i = TAG_W'(rt);
  endtask

  task automatic idle(int ff);
    drive(0, 0, 0, 0, 0, ff, 0, 0);
  endtask

  // run until empty, retiring the oldest outstanding tag each cycle
  task automatic drain();
    for (int c = 0; c < 40; c++) begin
      if (outstanding.size() > 0) drive(0, 0, 0, 0, 0, 3, 1, outstanding[0]);
      else idle(3);
      step();
    end
    idle(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int tmp, oldest_tag;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NSLOT; s++) begin s_live[s] = 0; s_rd[s] = 0; end
    for (int i = 0; i < DEPTH; i++) begin m_op[i] = 0; m_rd[i] = 0; m_tag[i] = 0; m_dep[i] = 0; end
    fu_free_i = '1;
    repeat (2) @(negedge clk);
    #1;
    chk(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
    chk(iss_valid_o == 1'b0, "R1", int'(iss_valid_o), 0);
    rst_ni = 1'b1;
    idle(3);
    step();
    chk(in_ready_o == 1'b1 && iss_valid_o == 1'b0, "R1", int'(iss_valid_o), 0);

    // R2: fill with units busy; fifth offer refused and not stored
    for (int k = 0; k < 5; k++) begin drive(1, 16 + k, 8 + k, 0, 0, 0, 0, 0); step(); end
    #1 chk(in_ready_o == 1'b0, "R2", int'(in_ready_o), 0);
    // R7: only unit 1 free
    drive(0, 0, 0, 0, 0, 2, 0, 0); #1;
    chk(iss_fu_o == 2'b10 && iss_op_o == 8'd16, "R7", int'(iss_fu_o), 2);
    step();
    drain();

    // R3: tags exhaust before the queue fills
    for (int k = 0; k < 7; k++) begin drive(1, 32 + k, 1, 0, 0, 1, 0, 0); step(); end
    #1 chk(in_ready_o == 1'b0, "R3", int'(in_ready_o), 0);
    drain();

    // R4 R6: A rd3, B reads 3, C rd5 reads 4, D reads 5
    drive(1, 65, 3, 0, 0, 0, 0, 0); step();
    drive(1, 66, 9, 3, 0, 0, 0, 0); step();
    drive(1, 67, 5, 4, 0, 0, 0, 0); step();
    drive(1, 68, 10, 0, 5, 0, 0, 0); step();
    idle(1); #1 chk(iss_op_o == 8'd65, "R6", int'(iss_op_o), 65);
    oldest_tag = int'(iss_tag_o);
    step();
    idle(1); #1 chk(iss_valid_o && iss_op_o == 8'd67, "R6", int'(iss_op_o), 67);
    step();
    idle(1); #1 chk(iss_valid_o == 1'b0, "R4", int'(iss_valid_o), 0);
    step();
    drive(0, 0, 0, 0, 0, 1, 1, oldest_tag); step();
    idle(1); #1 chk(iss_valid_o && iss_op_o == 8'd66, "R8", int'(iss_op_o), 66);
    step();
    drain();

    // R5: x0 destination and sources create no wait
    drive(1, 80, 0, 0, 0, 0, 0, 0); step();
    drive(1, 81, 6, 0, 0, 0, 0, 0); step();
    idle(1); step();
    idle(1); #1 chk(iss_valid_o && iss_op_o == 8'd81, "R5", int'(iss_op_o), 81);
    step();
    drain();

    // R8: consumer accepted on the edge where its producer retires
    drive(1, 90, 7, 0, 0, 1, 0, 0); step();
    idle(1); oldest_tag = int'(iss_tag_o); step();
    drive(1, 91, 2, 7, 0, 0, 1, oldest_tag); step();
    idle(1); #1 chk(iss_valid_o && iss_op_o == 8'd91, "R8", int'(iss_op_o), 91);
    step();
    drain();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      bit rv; int rt;
      rv = 0; rt = 0;
      if (outstanding.size() > 0 && ($urandom % 3) != 0) begin
        tmp = int'($urandom % outstanding.size());
        rv = 1; rt = outstanding[tmp];
      end
      drive(($urandom % 10) < 7, int'($urandom % 256), int'($urandom % 8),
            int'($urandom % 8), int'($urandom % 8), int'($urandom % 4), rv, rt);
      step();
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule